// File: doc/BRIEF.md
# Read Latency Calibration Unit

This block finds, once after memory initialization, the real round-trip delay of the read path. After a start pulse it waits for one read command. It then counts clock edges until the data captured from the memory I/O equals a fixed training word. The training word is 0xAA repeated on the rising-edge half and 0x55 repeated on the falling-edge half. Each data group has its own comparator and counter, so each group gets its own measured count.

When a group has a count, it delays the controller's read-enable strobe by that count plus one register stage. The delayed strobe then lines up with valid read data, and the read-data FIFO captures that data. The count is fixed once it is found and stays fixed until reset. A group that never sees the pattern within its count range reports an error instead. User traffic is only accepted once every group reports done.

Top module: `rdlat_cal`

## Requirements
- R1: After a synchronous reset, `cal_done`, `cal_err` and every bit of `rden_dly` and `lat_count` are 0.
- R2: Before a `cal_start` pulse, `rd_cmd` and matching data are ignored. No group completes, and a later start still measures from its own command.
- R3: Edge E0 is the first edge after `cal_start` at which `rd_cmd` is high. A group's count is k-1, where E0+k is the first later edge at which that group's data matches. The group's done goes high right after that edge.
- R4: A group matches only when its rising half equals 0xAA in every byte and its falling half equals 0x55 in every byte. A match on the rising half alone is not accepted.
- R5: If a group sees no match at edges E0+1 through E0+16, that group stops with its error set and its done low. Count 15 (a match at E0+16) is still accepted.
- R6: Each group measures its own count independently. Group g's count appears on `lat_count[4g+3:4g]`.
- R7: Once group g is done with count c, a one-cycle `ctrl_rden` pulse sampled at edge E makes `rden_dly[g]` high for exactly the one cycle after edge E+c.
- R8: `rden_dly[g]` stays low while group g is not done, including after a timeout.
- R9: Once a group is done, it stays done and its count stays frozen until reset. Further `cal_start`, `rd_cmd` and pattern data have no effect.
- R10: `cal_done` is high only when every group is done. `cal_err` is high when any group has timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Arms calibration (acted on only before it begins) |
| rd_cmd | input | 1 | Read command strobe; the first one after arming starts the count |
| rd_rise | input | NUM_GROUPS*GROUP_W | Captured rising-edge data, group g in bits [GROUP_W*g +: GROUP_W] |
| rd_fall | input | NUM_GROUPS*GROUP_W | Captured falling-edge data, same grouping |
| ctrl_rden | input | 1 | Controller read-enable strobe to be delayed |
| lat_count | output | NUM_GROUPS*4 | Measured count per group |
| rden_dly | output | NUM_GROUPS | Delayed read-enable per group |
| cal_done | output | 1 | All groups calibrated |
| cal_err | output | 1 | At least one group timed out |

## Verification
An off-by-one in the counter shows up two ways. `lat_count` reads one away from the delay the bench drove as soon as done rises. The `rden_dly` pulse also lands one cycle early or late on the first strobe after calibration. A comparator that accepts only half the pattern sets done at the half-match edge, so the count is low by the gap between the two matches. A state machine that does not hold its final state shows up in the next stimulus after done: a fresh start and command with a different delay change the count or drop done within a few cycles. A group that times out but is wrongly left able to complete would raise `cal_done` or pass a strobe on `rden_dly`.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
    localparam int          CNT_W      = 4;
    localparam int          MAX_CNT    = (1 << CNT_W) - 1;
    localparam int          LINE_DEPTH = 1 << CNT_W;
    localparam logic [7:0]  PAT_RISE_B = 8'hAA;
    localparam logic [7:0]  PAT_FALL_B = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MEAS,
        ST_DONE,
        ST_FAIL
    } cal_state_e;

    typedef struct packed {
        logic             done;
        logic             err;
        logic [CNT_W-1:0] lat;
    } grp_status_t;
endpackage

// File: rtl/rdlat_pattern_match.sv
module rdlat_pattern_match
    import rdlat_pkg::*;
#(
    parameter int GROUP_W = 8
) (
    input  logic [GROUP_W-1:0] rise,
    input  logic [GROUP_W-1:0] fall,
    output logic               hit
);
    localparam int NBYTES = GROUP_W / 8;
    localparam logic [GROUP_W-1:0] EXP_RISE = {NBYTES{PAT_RISE_B}};
    localparam logic [GROUP_W-1:0] EXP_FALL = {NBYTES{PAT_FALL_B}};

    // both halves must agree with the training word
    always_comb hit = (rise == EXP_RISE) && (fall == EXP_FALL);

    initial assert (GROUP_W % 8 == 0 && GROUP_W > 0)
        else $error("GROUP_W must be a positive multiple of 8");
endmodule

// File: rtl/rdlat_meas.sv
module rdlat_meas
    import rdlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_cmd,
    input  logic        hit,
    output grp_status_t stat
);
    cal_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lat_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_q <= ST_ARMED;
                ST_ARMED: if (rd_cmd) begin
                    state_q <= ST_MEAS;
                    cnt_q   <= '0;
                end
                ST_MEAS: begin
                    if (hit) begin
                        lat_q   <= cnt_q;
                        state_q <= ST_DONE;
                    end else if (cnt_q == CNT_W'(MAX_CNT)) begin
                        state_q <= ST_FAIL;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_DONE;
                ST_FAIL: state_q <= ST_FAIL;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        stat.done = (state_q == ST_DONE);
        stat.err  = (state_q == ST_FAIL);
        stat.lat  = lat_q;
    end

    // R9: completion is permanent
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        stat.done |=> stat.done);
    // R9: count frozen after completion
    p_lat_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (stat.done && $past(stat.done)) |-> $stable(stat.lat));
    // R5: done and error never together
    p_done_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(stat.done && stat.err));
    // R5: error only after the last count value was tried
    p_err_at_limit_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.err) |-> $past(cnt_q) == CNT_W'(MAX_CNT));
    // R3: a comparator hit while measuring completes the group
    p_match_done_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEAS && hit) |=> stat.done);
endmodule

// File: rtl/rdlat_delay_line.sv
module rdlat_delay_line
    import rdlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] sel,
    input  logic             strobe_in,
    output logic             strobe_out
);
    logic [LINE_DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[LINE_DEPTH-2:0], strobe_in};
    end

    // tap 0 is one register stage after the input
    always_comb strobe_out = en & sr_q[sel];

    // R7: a zero count gives exactly one cycle of delay
    p_zero_tap_r7: assert property (@(posedge clk) disable iff (rst)
        (en && sel == '0 && $past(en) && $past(sel) == '0)
            |-> strobe_out == $past(strobe_in));
    // R8: nothing passes before calibration
    p_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !strobe_out);
endmodule

// File: rtl/rdlat_cal.sv
module rdlat_cal
    import rdlat_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cal_start,
    input  logic                          rd_cmd,
    input  logic [NUM_GROUPS*GROUP_W-1:0] rd_rise,
    input  logic [NUM_GROUPS*GROUP_W-1:0] rd_fall,
    input  logic                          ctrl_rden,
    output logic [NUM_GROUPS*CNT_W-1:0]   lat_count,
    output logic [NUM_GROUPS-1:0]         rden_dly,
    output logic                          cal_done,
    output logic                          cal_err
);
    logic [NUM_GROUPS-1:0] done_v;
    logic [NUM_GROUPS-1:0] err_v;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic        hit;
        grp_status_t st;

        rdlat_pattern_match #(.GROUP_W(GROUP_W)) u_cmp (
            .rise (rd_rise[g*GROUP_W +: GROUP_W]),
            .fall (rd_fall[g*GROUP_W +: GROUP_W]),
            .hit  (hit)
        );

        rdlat_meas u_meas (
            .clk    (clk),
            .rst    (rst),
            .start  (cal_start),
            .rd_cmd (rd_cmd),
            .hit    (hit),
            .stat   (st)
        );

        rdlat_delay_line u_line (
            .clk        (clk),
            .rst        (rst),
            .en         (st.done),
            .sel        (st.lat),
            .strobe_in  (ctrl_rden),
            .strobe_out (rden_dly[g])
        );

        assign lat_count[g*CNT_W +: CNT_W] = st.lat;
        assign done_v[g] = st.done;
        assign err_v[g]  = st.err;
    end

    assign cal_done = &done_v;
    assign cal_err  = |err_v;

    // R10: overall done and any error cannot coexist
    p_done_vs_err_r10: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && cal_err));
    // R9: overall done is permanent
    p_cal_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done);
endmodule

// File: tb/rdlat_cal_tb_top.sv
module rdlat_cal_tb_top;
    localparam int NG = 2;
    localparam int GW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_start = 1'b0;
    logic rd_cmd = 1'b0;
    logic ctrl_rden = 1'b0;
    logic [NG*GW-1:0] rd_rise = '0;
    logic [NG*GW-1:0] rd_fall = '0;
    logic [NG*4-1:0]  lat_count;
    logic [NG-1:0]    rden_dly;
    logic cal_done, cal_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rdlat_cal #(.NUM_GROUPS(NG), .GROUP_W(GW)) dut_i (
        .clk(clk), .rst(rst), .cal_start(cal_start), .rd_cmd(rd_cmd),
        .rd_rise(rd_rise), .rd_fall(rd_fall), .ctrl_rden(ctrl_rden),
        .lat_count(lat_count), .rden_dly(rden_dly),
        .cal_done(cal_done), .cal_err(cal_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cal_start = 0; rd_cmd = 0; ctrl_rden = 0; rd_rise = '0; rd_fall = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    function automatic int lat_of(input int g);
        return int'(lat_count[g*4 +: 4]);
    endfunction

    // drive a start, a command, then data where group g fully matches at
    // edge E0+d_g and rising-only matches at E0+h_g (-1 means none)
    task automatic cal_seq(input bit do_start, input int d0, input int h0,
                           input int d1, input int h1);
        if (do_start) begin
            cal_start = 1; tick(); cal_start = 0;
        end
        rd_cmd = 1; tick(); rd_cmd = 0;
        for (int k = 1; k <= 20; k++) begin
            rd_rise[0 +: GW] = (k == d0 || k == h0) ? 8'hAA : 8'h00;
            rd_fall[0 +: GW] = (k == d0) ? 8'h55 : 8'h00;
            rd_rise[GW +: GW] = (k == d1 || k == h1) ? 8'hAA : 8'h00;
            rd_fall[GW +: GW] = (k == d1) ? 8'h55 : 8'h00;
            tick();
        end
        rd_rise = '0; rd_fall = '0;
    endtask

    // pulse ctrl_rden once and check the delayed copy on every following cycle
    task automatic check_delay(input int g, input int c, input string req);
        int hits = 0;
        int pos  = -1;
        ctrl_rden = 1; tick(); ctrl_rden = 0;
        for (int j = 0; j <= 18; j++) begin
            if (rden_dly[g]) begin hits++; pos = j; end
            tick();
        end
        if (c < 0) begin
            check(req, hits, 0);
        end else begin
            check(req, hits, 1);
            check(req, pos, c);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", int'(cal_done), 0);
        check("R1", int'(cal_err), 0);
        check("R1", int'(rden_dly), 0);
        check("R1", int'(lat_count), 0);
    endtask

    task automatic t_ignore_before_start();
        do_reset();
        cal_seq(1'b0, 1, -1, 1, -1);
        check("R2", int'(cal_done), 0);
        check("R8", int'(cal_err), 0);
        check_delay(0, -1, "R8");
        cal_seq(1'b1, 4, -1, 7, -1);
        check("R2", lat_of(0), 3);
        check("R2", lat_of(1), 6);
    endtask

    task automatic t_basic();
        do_reset();
        cal_seq(1'b1, 3, -1, 6, -1);
        check("R3", lat_of(0), 2);
        check("R6", lat_of(1), 5);
        check("R10", int'(cal_done), 1);
        check("R10", int'(cal_err), 0);
        check_delay(0, 2, "R7");
        check_delay(1, 5, "R7");
    endtask

    task automatic t_sticky();
        cal_seq(1'b1, 9, -1, 1, -1);
        check("R9", lat_of(0), 2);
        check("R9", lat_of(1), 5);
        check("R9", int'(cal_done), 1);
        check_delay(1, 5, "R9");
    endtask

    task automatic t_half_match();
        do_reset();
        cal_seq(1'b1, 4, 2, 1, -1);
        check("R4", lat_of(0), 3);
        check("R3", lat_of(1), 0);
        check_delay(1, 0, "R7");
        check_delay(0, 3, "R7");
    endtask

    task automatic t_boundary();
        do_reset();
        cal_seq(1'b1, 16, -1, 17, -1);
        check("R5", lat_of(0), 15);
        check("R5", int'(cal_err), 1);
        check("R10", int'(cal_done), 0);
        check_delay(1, -1, "R8");
        check_delay(0, 15, "R7");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ignore_before_start();
                t_basic();
                t_sticky();
                t_half_match();
                t_boundary();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule